// File: doc/BRIEF.md
# Memory Card Socket Status Register Block

This block is a small set of platform control words on a word-addressed register bus. It returns a fixed board identification word and a fixed decode word. It also holds one interrupt word that reports the state of a memory card socket. Bit 0 of that word tracks the socket's write-protect level. Bit 3 is a sticky flag that a card-insert event sets. While the flag is set, the block drives an interrupt line. Software clears the flag by writing a 1 to bit 3. A flash-programming word exists only as an address: writes to it are accepted and change nothing.

Both socket inputs pass through a synchroniser. The card-insert input is then edge-detected, so a level held high across a clear does not set the flag again. Only the next rising edge does. If a rising edge and a clear land in the same cycle, the event wins. Read data and the error flag are registered and appear one cycle after the access.

Top module: `cdr_ctrl_regs`

## Requirements
- R1: A read of word 0 returns 0x41034003.
- R2: A read of word 1 returns 0 and a read of word 3 returns 0x11.
- R3: Bit 0 of word 2 reads the level of `wp_in`, delayed by SYNC_STAGES cycles.
- R4: A rising edge on `card_in` sets bit 3 of word 2 and raises `card_irq` SYNC_STAGES+1 cycles later. A low `card_in` never clears the flag.
- R5: A write to word 2 clears bit 3, and lowers `card_irq`, only when write data bit 3 is 1. Other written bits have no effect. After the write, `card_irq` equals the remaining bit 3.
- R6: A `card_in` level held high across a clear does not set the flag again. A later rising edge does.
- R7: When a rising edge and a clearing write fall in the same cycle, the flag ends up set.
- R8: Bits 1, 2 and 4 and above of word 2 read as 0. After reset, word 2 reads 0 and `card_irq` is low.
- R9: Writes to words 1 and 3 are accepted without error and change neither word 2 nor `card_irq`.
- R10: A read of any word above 3, or a write to word 0 or any word above 3, raises `bus_err` for one cycle with `bus_rdata` equal to 0.
- R11: `bus_rdata` and `bus_err` update on the cycle after an access. `bus_rdata` holds its value while no access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_err | output | 1 | Bad-access pulse, registered |
| wp_in | input | 1 | Socket write-protect level |
| card_in | input | 1 | Socket card-insert signal |
| card_irq | output | 1 | Card-insert interrupt |

## Verification
The bench uses the default build: SYNC_STAGES=2, ADDR_W=4 and DATA_W=32. Two synchroniser stages make every socket-to-register delay a known count of cycles. That lets the bench place a rising edge in exactly the cycle of a clearing write, which tests the event-over-clear priority. A four-bit address covers the full range of unmapped words, up to word 15, so the error response is checked both just past the mapped words and at the top of the space.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

    localparam int unsigned WORD_ID   = 0;
    localparam int unsigned WORD_PROG = 1;
    localparam int unsigned WORD_STAT = 2;
    localparam int unsigned WORD_DEC  = 3;

    localparam int unsigned BIT_WP   = 0;
    localparam int unsigned BIT_CARD = 3;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RD_ID,
        ACC_RD_ZERO,
        ACC_RD_STAT,
        ACC_RD_DEC,
        ACC_WR_STAT,
        ACC_WR_IGN,
        ACC_BAD
    } acc_e;

endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else if (STAGES == 1) begin : g_one
            logic s_d, s_q;
            always_comb s_d = din;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= 1'b0;
                else        s_q <= s_d;
            end
            assign dout = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] s_d, s_q;
            always_comb s_d = {s_q[STAGES-2:0], din};
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= s_d;
            end
            assign dout = s_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cdr_rise_latch.sv
module cdr_rise_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic clr,
    output logic rise,
    output logic flag
);
    typedef struct packed {
        logic prev;
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        rise      = lvl & ~st_q.prev;
        st_d.prev = lvl;
        // a new event outranks a clear in the same cycle
        st_d.flag = rise | (st_q.flag & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/cdr_addr_dec.sv
module cdr_addr_dec
    import cdr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output acc_e              kind
);
    always_comb begin
        kind = ACC_NONE;
        if (sel) begin
            kind = ACC_BAD;
            if (addr == ADDR_W'(WORD_ID)) begin
                kind = wr ? ACC_BAD : ACC_RD_ID;
            end else if (addr == ADDR_W'(WORD_PROG)) begin
                kind = wr ? ACC_WR_IGN : ACC_RD_ZERO;
            end else if (addr == ADDR_W'(WORD_STAT)) begin
                kind = wr ? ACC_WR_STAT : ACC_RD_STAT;
            end else if (addr == ADDR_W'(WORD_DEC)) begin
                kind = wr ? ACC_WR_IGN : ACC_RD_DEC;
            end
        end
    end
endmodule

// File: rtl/cdr_ctrl_regs.sv
module cdr_ctrl_regs
    import cdr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] ID_WORD  = DATA_W'(32'h4103_4003),
    parameter logic [DATA_W-1:0] DEC_WORD = DATA_W'(32'h0000_0011)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              wp_in,
    input  logic              card_in,
    output logic              card_irq
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    acc_e kind;
    logic wp_s, card_s;
    logic ev_rise, ev_flag, ev_clr;
    logic [DATA_W-1:0] stat_word;

    cdr_sync #(.STAGES(SYNC_STAGES)) u_wp_sync (
        .clk(clk), .rst_n(rst_n), .din(wp_in), .dout(wp_s)
    );

    cdr_sync #(.STAGES(SYNC_STAGES)) u_card_sync (
        .clk(clk), .rst_n(rst_n), .din(card_in), .dout(card_s)
    );

    cdr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .kind(kind)
    );

    assign ev_clr = (kind == ACC_WR_STAT) && bus_wdata[BIT_CARD];

    cdr_rise_latch u_card_latch (
        .clk(clk), .rst_n(rst_n), .lvl(card_s), .clr(ev_clr),
        .rise(ev_rise), .flag(ev_flag)
    );

    always_comb begin
        stat_word           = '0;
        stat_word[BIT_WP]   = wp_s;
        stat_word[BIT_CARD] = ev_flag;
    end

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.err = 1'b0;
        unique case (kind)
            ACC_RD_ID:   rsp_d.rdata = ID_WORD;
            ACC_RD_ZERO: rsp_d.rdata = '0;
            ACC_RD_STAT: rsp_d.rdata = stat_word;
            ACC_RD_DEC:  rsp_d.rdata = DEC_WORD;
            ACC_BAD: begin
                rsp_d.rdata = '0;
                rsp_d.err   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_rdata = rsp_q.rdata;
    assign bus_err   = rsp_q.err;
    assign card_irq  = ev_flag;
endmodule

// File: rtl/cdr_ctrl_regs_chk.sv
module cdr_ctrl_regs_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic              card_irq,
    input logic              ev_rise
);
    localparam logic [DATA_W-1:0] RSV_MASK = ~DATA_W'(32'h9);

    p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_irq) |-> $past(ev_rise));

    p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_irq) |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(2) && bus_wdata[3]));

    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_sel && !bus_wr && bus_addr == ADDR_W'(2)) |-> (bus_rdata & RSV_MASK) == '0);

    p_ign_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr == ADDR_W'(1) || bus_addr == ADDR_W'(3)) && !ev_rise)
        |=> ($stable(card_irq) && !bus_err));

    p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ($past(bus_sel) && bus_rdata == '0));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel) |-> $stable(bus_rdata));
endmodule

bind cdr_ctrl_regs cdr_ctrl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .card_irq(card_irq), .ev_rise(ev_rise)
);

// File: tb/cdr_ctrl_regs_tb.sv
`timescale 1ns/1ps
module cdr_ctrl_regs_tb;
    localparam int unsigned SYNC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        wp_in = 1'b0;
    logic        card_in = 1'b0;
    logic        card_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cdr_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .wp_in(wp_in), .card_in(card_in), .card_irq(card_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b0, 4'd0,  32'h0,        32'h4103_4003, 1'b0, 8'd1},  // R1
        '{1'b0, 4'd1,  32'h0,        32'h0,         1'b0, 8'd2},  // R2
        '{1'b0, 4'd3,  32'h0,        32'h11,        1'b0, 8'd2},
        '{1'b1, 4'd1,  32'hFFFF_FFFF, 32'h11,       1'b0, 8'd9},  // R9: rdata holds
        '{1'b1, 4'd3,  32'hFFFF_FFFF, 32'h11,       1'b0, 8'd9},
        '{1'b0, 4'd2,  32'h0,        32'h0,         1'b0, 8'd8},  // R8
        '{1'b0, 4'd4,  32'h0,        32'h0,         1'b1, 8'd10}, // R10
        '{1'b0, 4'd15, 32'h0,        32'h0,         1'b1, 8'd10},
        '{1'b1, 4'd0,  32'h1234,     32'h0,         1'b1, 8'd10},
        '{1'b1, 4'd7,  32'h8,        32'h0,         1'b1, 8'd10}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, committed at the next rising edge, sampled one falling edge later
    task automatic access(input logic wr, input logic [3:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd = bus_rdata; er = bus_err;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        logic [31:0] held;

        wait_cyc(3);
        chk("R8 reset irq", {31'b0, card_irq}, 32'h0);
        chk("R8 reset err", {31'b0, bus_err}, 32'h0);
        rst_n = 1'b1;
        wait_cyc(2);

        foreach (VECS[i]) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, rd, er);
            chk($sformatf("R%0d vec%0d rdata", VECS[i].req, i), rd, VECS[i].exp_rd);
            chk($sformatf("R%0d vec%0d err", VECS[i].req, i), {31'b0, er}, {31'b0, VECS[i].exp_err});
        end

        // R11: rdata holds while idle, err is a single pulse
        access(1'b0, 4'd0, 32'h0, rd, er);
        wait_cyc(3);
        chk("R11 hold", bus_rdata, 32'h4103_4003);
        access(1'b0, 4'd9, 32'h0, rd, er);
        wait_cyc(1);
        chk("R11 err pulse", {31'b0, bus_err}, 32'h0);

        // R3: write-protect level
        wp_in = 1'b1;
        wait_cyc(SYNC + 1);
        access(1'b0, 4'd2, 32'h0, rd, er);
        chk("R3 wp high", rd, 32'h1);
        wp_in = 1'b0;
        wait_cyc(SYNC + 1);
        access(1'b0, 4'd2, 32'h0, rd, er);
        chk("R3 wp low", rd, 32'h0);

        // R4: rising edge latches, low input keeps it
        card_in = 1'b1;
        wait_cyc(SYNC + 2);
        chk("R4 irq set", {31'b0, card_irq}, 32'h1);
        card_in = 1'b0;
        wait_cyc(6);
        chk("R4 low keeps irq", {31'b0, card_irq}, 32'h1);
        access(1'b0, 4'd2, 32'h0, rd, er);
        chk("R4 stat", rd, 32'h8);

        // R5: writes without bit 3 do nothing
        access(1'b1, 4'd2, 32'hFFFF_FFF7, rd, er);
        chk("R5 no clear irq", {31'b0, card_irq}, 32'h1);
        // R9: ignored words leave the flag alone
        access(1'b1, 4'd1, 32'hFFFF_FFFF, rd, er);
        chk("R9 prog err", {31'b0, er}, 32'h0);
        access(1'b1, 4'd3, 32'hFFFF_FFFF, rd, er);
        chk("R9 irq kept", {31'b0, card_irq}, 32'h1);
        // R8: reserved bits with both status bits set
        wp_in = 1'b1;
        wait_cyc(SYNC + 1);
        access(1'b0, 4'd2, 32'h0, rd, er);
        chk("R8 reserved zero", rd, 32'h9);
        wp_in = 1'b0;
        wait_cyc(SYNC + 1);
        // R5: clear
        access(1'b1, 4'd2, 32'h8, rd, er);
        chk("R5 irq cleared", {31'b0, card_irq}, 32'h0);
        access(1'b0, 4'd2, 32'h0, rd, er);
        chk("R5 stat cleared", rd, 32'h0);

        // R6: held level does not retrigger
        card_in = 1'b1;
        wait_cyc(SYNC + 2);
        access(1'b1, 4'd2, 32'h8, rd, er);
        wait_cyc(6);
        chk("R6 no retrigger", {31'b0, card_irq}, 32'h0);
        card_in = 1'b0;
        wait_cyc(SYNC + 2);
        card_in = 1'b1;
        wait_cyc(SYNC + 2);
        chk("R6 new edge", {31'b0, card_irq}, 32'h1);
        access(1'b1, 4'd2, 32'h8, rd, er);
        card_in = 1'b0;
        wait_cyc(SYNC + 3);
        chk("R6 cleared", {31'b0, card_irq}, 32'h0);

        // R7: edge in the same cycle as a clearing write
        @(negedge clk);
        card_in = 1'b1;
        wait_cyc(SYNC - 1);
        access(1'b1, 4'd2, 32'h8, rd, er);
        wait_cyc(1);
        chk("R7 event wins", {31'b0, card_irq}, 32'h1);
        card_in = 1'b0;

        // R8: reset returns to zero
        held = bus_rdata;
        rst_n = 1'b0;
        wait_cyc(2);
        chk("R8 reset clears irq", {31'b0, card_irq}, 32'h0);
        rst_n = 1'b1;
        wait_cyc(SYNC + 2);
        access(1'b0, 4'd2, 32'h0, rd, er);
        chk("R8 stat after reset", rd, 32'h0);
        chk("R8 irq after reset", {31'b0, card_irq}, 32'h0);
        if (held === 32'hx) $display("note: held unknown");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule